// File: doc/BRIEF.md
# Receive Buffer Address Queue

A network input needs memory buffers to hold remote function requests as they arrive. This block keeps a small circular queue of buffer base addresses for that purpose. The processor hands over buffers one at a time by pulsing a push strobe with an address. The receive logic always sees the address at the front of the queue, so it can start writing a message there before it commits to that buffer.

Once a request has been stored completely, the receive logic pulses a consume strobe together with a good-message qualifier. The front entry is retired only when that qualifier shows the message was stored without corruption. Otherwise the same buffer is reused for the next message.

A status word reports the front and back indices, full and empty flags, and a sticky overflow flag. An interrupt, gated by an enable input, asks the processor for more buffers whenever the queue has none left.

Top module: `rxq_buf_queue`

## Requirements
- R1: After synchronous reset both indices are 0, the queue is empty, full is 0 and overflow is 0.
- R2: A push on a non-full queue stores `push_addr_i` in the slot at the tail index, and the tail index advances by one modulo 8 on the same clock edge.
- R3: The queue holds at most seven addresses. The full flag is 1 exactly when tail equals head plus 7 modulo 8, and full and empty are never 1 together.
- R4: A push while full changes neither index nor any stored address. It sets the overflow flag, which then stays 1 until reset.
- R5: The empty flag is 1 exactly when the head and tail indices are equal.
- R6: A consume with the good qualifier high advances the head by one modulo 8. A consume with the qualifier low leaves the head unchanged.
- R7: A consume while the queue is empty is ignored, and the head does not move.
- R8: `head_addr_o` continuously shows the address stored at the head slot. Addresses come out in the order they were pushed, including across index wrap.
- R9: `irq_o` is 1 exactly when `irq_en_i` is 1 and the queue is empty.
- R10: The status word is laid out as follows: bits 2:0 head index, bits 5:3 tail index, bit 6 full, bit 7 empty, bit 8 overflow.
- R11: A push and a good consume in the same cycle on a queue that is neither full nor empty both take effect, and the entry count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Append `push_addr_i` at the tail |
| push_addr_i | input | 32 | Buffer address to append |
| consume_i | input | 1 | Receive logic finished with the head buffer |
| consume_ok_i | input | 1 | The finished message was stored uncorrupted |
| irq_en_i | input | 1 | Enable for the buffer-request interrupt |
| head_addr_o | output | 32 | Address stored at the head slot |
| status_o | output | 9 | {overflow, empty, full, tail, head} |
| irq_o | output | 1 | Request for more buffers |

## Verification
The embedded properties assume the strobes are never unknown after reset. They also assume `consume_ok_i` is only meaningful in a cycle where `consume_i` is high. The bench meets both assumptions by driving every input to a defined level at the falling edge and holding it for exactly one clock. It raises the qualifier only alongside a consume, apart from one deliberate check that the qualifier alone does nothing. Pushes against a full queue and consumes against an empty one are issued on purpose, because the properties cover those cases rather than exclude them.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 3;
    localparam int SLOTS  = 1 << IDX_W;
    localparam int STAT_W = 2 * IDX_W + 3;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic ovf;
        logic empty;
        logic full;
        idx_t tail;
        idx_t head;
    } rxq_status_t;

    function automatic idx_t idx_inc(idx_t i);
        return idx_t'(i + idx_t'(1));
    endfunction
endpackage

// File: rtl/rxq_slot_store.sv
module rxq_slot_store
    import rxq_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  wr_en_i,
    input  idx_t  wr_idx_i,
    input  addr_t wr_data_i,
    input  idx_t  rd_idx_i,
    output addr_t rd_data_o
);
    addr_t slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (rst_i)
                slot_q[g] <= '0;
            else if (wr_en_i && (wr_idx_i == idx_t'(g)))
                slot_q[g] <= wr_data_i;
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl
    import rxq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic push_i,
    input  logic take_i,
    output idx_t head_o,
    output idx_t tail_o,
    output logic full_o,
    output logic empty_o,
    output logic ovf_o,
    output logic wr_en_o
);
    idx_t head_q, tail_q;
    logic ovf_q;
    logic do_push, do_take;

    assign empty_o = (head_q == tail_q);
    assign full_o  = (idx_t'(tail_q - head_q) == idx_t'(SLOTS - 1));
    assign do_push = push_i && !full_o;
    assign do_take = take_i && !empty_o;
    assign wr_en_o = do_push;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            head_q <= '0;
            tail_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (do_push) tail_q <= idx_inc(tail_q);
            if (do_take) head_q <= idx_inc(head_q);
            if (push_i && full_o) ovf_q <= 1'b1;
        end
    end

    assign head_o = head_q;
    assign tail_o = tail_q;
    assign ovf_o  = ovf_q;

    AST_TAIL_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (push_i && !full_o) |=> (tail_q == idx_inc($past(tail_q)))); // R2
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        !(full_o && empty_o)); // R3
    AST_FULL_PUSH_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (push_i && full_o) |=> ($stable(tail_q) && ovf_q)); // R4
    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_q |=> ovf_q); // R4
    AST_BAD_MSG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !take_i |=> $stable(head_q)); // R6
    AST_EMPTY_TAKE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (take_i && empty_o) |=> $stable(head_q)); // R7
endmodule

// File: rtl/rxq_buf_queue.sv
module rxq_buf_queue
    import rxq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              consume_i,
    input  logic              consume_ok_i,
    input  logic              irq_en_i,
    output logic [ADDR_W-1:0] head_addr_o,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);
    idx_t        head, tail;
    logic        full, empty, ovf, wr_en;
    rxq_status_t stat;

    rxq_ptr_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .push_i  (push_i),
        .take_i  (consume_i && consume_ok_i),
        .head_o  (head),
        .tail_o  (tail),
        .full_o  (full),
        .empty_o (empty),
        .ovf_o   (ovf),
        .wr_en_o (wr_en)
    );

    rxq_slot_store u_store (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en),
        .wr_idx_i  (tail),
        .wr_data_i (push_addr_i),
        .rd_idx_i  (head),
        .rd_data_o (head_addr_o)
    );

    always_comb begin
        stat.head  = head;
        stat.tail  = tail;
        stat.full  = full;
        stat.empty = empty;
        stat.ovf   = ovf;
    end

    assign status_o = stat;
    assign irq_o    = irq_en_i && empty;

    AST_IRQ_ONLY_DRY: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (status_o[2:0] == status_o[5:3])); // R9
endmodule

// File: tb/rxq_buf_queue_tb_top.sv
module rxq_buf_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        push, cons, ok, en;
    logic [31:0] addr;
    logic [31:0] head_addr;
    logic [8:0]  status;
    logic        irq;

    int n_chk = 0, n_fail = 0;

    logic [31:0] m_mem [8];
    logic [2:0]  m_head, m_tail;
    logic        m_ovf;

    always #2 clk = ~clk;

    rxq_buf_queue dut_i (
        .clk_i(clk), .rst_i(rst), .push_i(push), .push_addr_i(addr),
        .consume_i(cons), .consume_ok_i(ok), .irq_en_i(en),
        .head_addr_o(head_addr), .status_o(status), .irq_o(irq)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic m_empty();
        return m_head == m_tail;
    endfunction
    function automatic logic m_full();
        return 3'(m_tail - m_head) == 3'd7;
    endfunction

    task automatic check_all(string req);
        chk({req, " status R10"}, {23'd0, status},
            {23'd0, m_ovf, m_empty(), m_full(), m_tail, m_head});
        chk({req, " irq R9"}, {31'd0, irq}, {31'd0, en && m_empty()});
        if (!m_empty()) chk({req, " head addr R8"}, head_addr, m_mem[m_head]);
    endtask

    task automatic step(logic p, logic [31:0] a, logic c, logic k);
        logic ef, ff;
        @(negedge clk);
        push = p; addr = a; cons = c; ok = k;
        ef = m_empty(); ff = m_full();
        @(negedge clk);
        push = 0; cons = 0; ok = 0;
        if (p && !ff) begin m_mem[m_tail] = a; m_tail = m_tail + 3'd1; end
        if (p && ff) m_ovf = 1'b1;
        if (c && k && !ef) m_head = m_head + 3'd1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; push = 0; cons = 0; ok = 0; addr = '0;
        @(negedge clk); @(negedge clk); rst = 0;
        m_head = 0; m_tail = 0; m_ovf = 0;
        check_all("R1 reset");
        chk("R1 empty", {31'd0, status[7]}, 32'd1);
    endtask

    task automatic t_push_basic();
        step(1, 32'h1000_0100, 0, 0);
        check_all("R2 push1");
        chk("R2 tail", {29'd0, status[5:3]}, 32'd1);
        step(1, 32'h1000_0200, 0, 0);
        step(1, 32'h1000_0300, 0, 0);
        check_all("R2 push3");
        chk("R8 head first", head_addr, 32'h1000_0100);
    endtask

    task automatic t_consume();
        step(0, 0, 1, 0);
        check_all("R6 bad msg");
        chk("R6 head held", {29'd0, status[2:0]}, 32'd0);
        step(0, 0, 0, 1);
        check_all("R6 ok alone");
        step(0, 0, 1, 1);
        check_all("R6 good msg");
        chk("R8 second", head_addr, 32'h1000_0200);
    endtask

    task automatic t_full();
        for (int i = 0; i < 6; i++) step(1, 32'hA000_0000 + i, 0, 0);
        check_all("R3 full");
        chk("R3 full bit", {31'd0, status[6]}, 32'd1);
        step(1, 32'hDEAD_BEEF, 0, 0);
        check_all("R4 overflow");
        chk("R4 ovf bit", {31'd0, status[8]}, 32'd1);
        step(1, 32'hBAD0_0000, 1, 1);
        check_all("R4 full push w/ consume");
    endtask

    task automatic t_drain();
        for (int i = 0; i < 6; i++) begin
            step(0, 0, 1, 1);
            check_all("R8 drain order");
        end
        chk("R5 empty", {31'd0, status[7]}, 32'd1);
        chk("R4 ovf stays", {31'd0, status[8]}, 32'd1);
        step(0, 0, 1, 1);
        check_all("R7 consume empty");
    endtask

    task automatic t_irq();
        en = 1; #1;
        check_all("R9 irq on");
        step(1, 32'h5555_0000, 0, 0);
        check_all("R9 irq off");
        step(0, 0, 1, 1);
        check_all("R9 irq again");
        en = 0; #1;
        check_all("R9 disabled");
    endtask

    task automatic t_wrap_simul();
        step(1, 32'h7000_0001, 0, 0);
        step(1, 32'h7000_0002, 0, 0);
        for (int i = 0; i < 10; i++) begin
            step(1, 32'h7100_0000 + i, 1, 1);
            check_all("R11 simul wrap");
        end
        chk("R11 count", {29'd0, 3'(status[5:3] - status[2:0])}, 32'd2);
    endtask

    initial begin
        rst = 1; push = 0; cons = 0; ok = 0; en = 0; addr = '0;
        do_reset();
        t_push_basic();
        t_consume();
        t_full();
        t_drain();
        t_irq();
        t_wrap_simul();
        do_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule